// File: doc/BRIEF.md
# Cascadable Bidirectional Column Driver Core

This block is the digital heart of a 96-column display data driver. Pixel bits arrive six at a time on a 6-bit bus and march through six parallel 16-stage shift chains. Each pulse of the shift qualifier moves them one stage. A direction input picks forward or reverse shifting. The same input also decides which 6-bit port takes data in and which port passes data on to the next driver, so several blocks can be chained into a line of any width.

A strobe-controlled holding stage freezes a copy of the 96 shifted bits. The column levels come from that copy. Two controls act on the levels: a blanking input pulls every column low, and a polarity force input drives every column high while blanking is inactive. The bidirectional ports appear as separate input, output and output-enable signals.

The design runs on one clock. The shift qualifier `shift_en` stands in for the rising edge of a dedicated shift clock. The strobe is sampled on the same clock edge.

Top module: `column_driver_core`

## Requirements
- R1: A synchronous active-low reset clears all shift stages and the held copy. After reset, with blanking and force inactive, `col_out` is all zero, and both `a_out` and `b_out` are zero.
- R2: With `dir_fwd`=1, every clock edge with `shift_en`=1 loads `a_in` into the six bits of columns 0..5 and moves each earlier word six columns up. Bus bit k of a word therefore lands in column 6*g+k, where g is the number of shifts since that word entered. The word in columns 90..95 appears on `b_out`, so the first word is on `b_out` after 16 shifts.
- R3: On a clock edge with `shift_en`=0, the shift stages keep their contents: `a_out`, `b_out` and any later copy are unchanged.
- R4: With `dir_fwd`=0, each shift loads `b_in` into columns 90..95 and moves each earlier word six columns down. The word in columns 0..5 appears on `a_out`, so the first word is on `a_out` after 16 shifts.
- R5: `b_oe` is 1 and `a_oe` is 0 when `dir_fwd`=1. `a_oe` is 1 and `b_oe` is 0 when `dir_fwd`=0. Exactly one of the two is ever set.
- R6: On a clock edge with `strobe_n`=0, the held copy takes the shift stage contents as they stood before that edge. While `strobe_n`=1, the held copy does not change, even if shifting goes on.
- R7: `blank_n`=0 drives all 96 columns to 0, whatever the data and whatever `force_hi_n` is.
- R8: `blank_n`=1 with `force_hi_n`=0 drives all 96 columns to 1.
- R9: `blank_n`=1 with `force_hi_n`=1 makes each column follow its held bit.
- R10: When one block's `b_out` feeds the next block's `a_in` and both shift together in forward mode, the pair behaves as a single 32-stage chain. After 32 shifts, the second block holds the first 16 words.
- R11: The port not selected as input has no effect: `b_in` is ignored in forward mode and `a_in` is ignored in reverse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Qualifies a shift on this clock edge |
| dir_fwd | input | 1 | 1 = forward (A in, B out), 0 = reverse (B in, A out) |
| a_in | input | 6 | Port A input value |
| a_out | output | 6 | Port A output value (word in columns 0..5) |
| a_oe | output | 1 | Port A output enable |
| b_in | input | 6 | Port B input value |
| b_out | output | 6 | Port B output value (word in columns 90..95) |
| b_oe | output | 1 | Port B output enable |
| strobe_n | input | 1 | Low: held copy loads the shift stages |
| blank_n | input | 1 | Low: all columns low |
| force_hi_n | input | 1 | Low with blanking inactive: all columns high |
| col_out | output | 96 | Column levels |

## Verification
Forward shifting uses a word sequence in which every word differs from its neighbours. Any error in lane order, column placement or stage count then shows up as a wrong bit position, not a silent match. Reverse shifting uses a second sequence while garbage toggles on the unused port. This separates a correct port swap from one that still listens to the wrong side.

Idle cycles with changing inputs show the difference between holding and shifting. A run of shifts with the strobe held high shows the difference between a copy that holds and one that tracks the chain. Two chained blocks show whether the cascade output carries the word that has left the last stage.

All four blanking and force combinations are applied to a held copy whose bits are neither all zero nor all one. Each output mode is therefore distinguishable from the others.

// File: rtl/col_drv_pkg.sv
`timescale 1ns/1ps
// Package col_drv_pkg
// Shared type for the column driver core: the shift direction encoding.
// Assumes the direction pin uses 1 for forward and 0 for reverse.
package col_drv_pkg;
    typedef enum logic {
        DIR_REV = 1'b0,
        DIR_FWD = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/col_shift_chain.sv
`timescale 1ns/1ps
// Module col_shift_chain
// LANES parallel chains of STAGES stages each, stored as one packed array.
// Stage s, lane k maps to column s*LANES+k. Forward shifting enters at
// stage 0 and leaves at the top stage. Reverse shifting enters at the top
// stage and leaves at stage 0.
// Assumes shift_en is a one-cycle qualifier standing in for a shift clock edge.
module col_shift_chain
    import col_drv_pkg::*;
#(
    parameter int LANES  = 6,
    parameter int STAGES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  shift_dir_e                dir,
    input  logic [LANES-1:0]          fwd_in,
    input  logic [LANES-1:0]          rev_in,
    output logic [LANES-1:0]          fwd_tap,
    output logic [LANES-1:0]          rev_tap,
    output logic [STAGES*LANES-1:0]   bits
);
    logic [STAGES-1:0][LANES-1:0] stage_q;

    // Shift one stage in the selected direction when qualified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (shift_en) begin
            if (dir == DIR_FWD) begin
                stage_q <= {stage_q[STAGES-2:0], fwd_in};
            end else begin
                stage_q <= {rev_in, stage_q[STAGES-1:1]};
            end
        end
    end

    // Expose both end stages and the flat column image.
    always_comb begin
        fwd_tap = stage_q[STAGES-1];
        rev_tap = stage_q[0];
        bits    = stage_q;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stage_q)); // R3
    AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && dir == DIR_FWD) |=> stage_q[0] == $past(fwd_in)); // R2
    AST_FWD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && dir == DIR_FWD) |=> stage_q[STAGES-1] == $past(stage_q[STAGES-2])); // R2
    AST_REV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && dir == DIR_REV) |=> stage_q[STAGES-1] == $past(rev_in)); // R4
    AST_REV_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && dir == DIR_REV) |=> stage_q[0] == $past(stage_q[1])); // R4
endmodule

// File: rtl/col_strobe_latch.sv
`timescale 1ns/1ps
// Module col_strobe_latch
// Held copy of the column image. Every clock edge with the strobe low loads
// the image. With the strobe high the copy is kept.
// Assumes the strobe is synchronous to clk.
module col_strobe_latch #(
    parameter int WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Load while the strobe is low, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!strobe_n) begin
            q <= d;
        end
    end

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> $stable(q)); // R6
    AST_STROBE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |=> q == $past(d)); // R6
endmodule

// File: rtl/col_out_stage.sv
`timescale 1ns/1ps
// Module col_out_stage
// Per-column level logic. Blanking forces low and wins over everything.
// Otherwise the force input drives high. Otherwise the column shows its
// held bit.
// Assumes both controls are active low and static between strobes.
module col_out_stage #(
    parameter int WIDTH = 96
) (
    input  logic             blank_n,
    input  logic             force_hi_n,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] drive
);
    for (genvar c = 0; c < WIDTH; c++) begin : g_col
        // One gate per column: blank low, else force high, else data.
        assign drive[c] = blank_n & (~force_hi_n | held[c]);
    end
endmodule

// File: rtl/column_driver_core.sv
`timescale 1ns/1ps
// Module column_driver_core
// Top of the column driver. A six-lane bidirectional shift chain feeds a
// strobed holding stage, which feeds the blanking/force output logic.
// Port roles swap with direction: the output enables tell the pad ring
// which port drives.
// Assumes direction changes only while shift_en is low.
module column_driver_core
    import col_drv_pkg::*;
#(
    parameter int LANES  = 6,
    parameter int STAGES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic                       dir_fwd,
    input  logic [LANES-1:0]           a_in,
    output logic [LANES-1:0]           a_out,
    output logic                       a_oe,
    input  logic [LANES-1:0]           b_in,
    output logic [LANES-1:0]           b_out,
    output logic                       b_oe,
    input  logic                       strobe_n,
    input  logic                       blank_n,
    input  logic                       force_hi_n,
    output logic [LANES*STAGES-1:0]    col_out
);
    localparam int COLS = LANES * STAGES;

    shift_dir_e       dir;
    logic [COLS-1:0]  image;
    logic [COLS-1:0]  held;

    // Decode direction and the port enables from it.
    always_comb begin
        dir  = shift_dir_e'(dir_fwd);
        b_oe = (dir == DIR_FWD);
        a_oe = (dir == DIR_REV);
    end

    col_shift_chain #(.LANES(LANES), .STAGES(STAGES)) i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .dir      (dir),
        .fwd_in   (a_in),
        .rev_in   (b_in),
        .fwd_tap  (b_out),
        .rev_tap  (a_out),
        .bits     (image)
    );

    col_strobe_latch #(.WIDTH(COLS)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .d        (image),
        .q        (held)
    );

    col_out_stage #(.WIDTH(COLS)) i_levels (
        .blank_n    (blank_n),
        .force_hi_n (force_hi_n),
        .held       (held),
        .drive      (col_out)
    );

    AST_ONE_PORT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_oe, b_oe}) == 1); // R5
    AST_BLANK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> col_out == '0); // R7
    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !force_hi_n) |-> &col_out); // R8
    AST_SHOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && force_hi_n && $stable(held)) |-> $stable(col_out)); // R9
endmodule

// File: tb/test_column_driver_core.sv
`timescale 1ns/1ps
// Directed bench: two chained column driver cores, one task per scenario.
module test_column_driver_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_en = 1'b0;
    logic        dir_fwd = 1'b1;
    logic        strobe_n = 1'b1;
    logic        blank_n = 1'b1;
    logic        force_hi_n = 1'b1;
    logic [5:0]  tb_a = '0;
    logic [5:0]  tb_b = '0;

    logic [5:0]  c1_a_out, c1_b_out, c2_a_out, c2_b_out;
    logic        c1_a_oe, c1_b_oe, c2_a_oe, c2_b_oe;
    logic [95:0] c1_col, c2_col;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [5:0] hist [64];
    int nw = 0;

    always #2.5 clk = ~clk;

    column_driver_core i_column_driver_core (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .dir_fwd(dir_fwd),
        .a_in(tb_a), .a_out(c1_a_out), .a_oe(c1_a_oe),
        .b_in(c2_a_out), .b_out(c1_b_out), .b_oe(c1_b_oe),
        .strobe_n(strobe_n), .blank_n(blank_n), .force_hi_n(force_hi_n),
        .col_out(c1_col)
    );

    column_driver_core i_column_driver_core_nxt (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .dir_fwd(dir_fwd),
        .a_in(c1_b_out), .a_out(c2_a_out), .a_oe(c2_a_oe),
        .b_in(tb_b), .b_out(c2_b_out), .b_oe(c2_b_oe),
        .strobe_n(strobe_n), .blank_n(blank_n), .force_hi_n(force_hi_n),
        .col_out(c2_col)
    );

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [5:0] word_at(input int idx);
        return (idx >= 0) ? hist[idx] : 6'd0;
    endfunction

    // Forward image of chip 0 or 1 in the 32-stage chain.
    function automatic logic [95:0] exp_fwd(input int chip);
        logic [95:0] r = '0;
        for (int s = 0; s < 16; s++) r[s*6 +: 6] = word_at(nw - 1 - (s + 16*chip));
        return r;
    endfunction

    // Reverse image of the block fed directly from the bench.
    function automatic logic [95:0] exp_rev();
        logic [95:0] r = '0;
        for (int s = 0; s < 16; s++) r[s*6 +: 6] = word_at(nw - 1 - (15 - s));
        return r;
    endfunction

    task automatic push(input logic [5:0] w, input logic [5:0] junk);
        if (dir_fwd) begin tb_a = w; tb_b = junk; end
        else         begin tb_b = w; tb_a = junk; end
        shift_en = 1'b1;
        tick();
        shift_en = 1'b0;
        hist[nw] = w;
        nw++;
    endtask

    task automatic latch_now();
        strobe_n = 1'b0;
        tick();
        strobe_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        strobe_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        strobe_n = 1'b1;
        nw = 0;
    endtask

    task automatic t_reset();
        dir_fwd = 1'b1;
        do_reset();
        strobe_n = 1'b0;
        tick();
        strobe_n = 1'b1;
        chk("R1 columns after reset", c1_col, '0);
        chk("R1 b_out after reset", {90'd0, c1_b_out}, '0);
        chk("R1 a_out after reset", {90'd0, c1_a_out}, '0);
        chk("R5 forward enables", {94'd0, c1_a_oe, c1_b_oe}, 96'd1);
    endtask

    task automatic t_forward();
        for (int i = 0; i < 16; i++) begin
            push(6'((i*23 + 7) & 63), 6'((i*5 + 42) & 63));
            chk("R2 b_out word", {90'd0, c1_b_out}, {90'd0, word_at(nw - 16)});
        end
        latch_now();
        chk("R2 forward column image", c1_col, exp_fwd(0));
        chk("R11 b_in ignored forward", c2_col, exp_fwd(1));
    endtask

    task automatic t_hold();
        logic [5:0] b_before = c1_b_out;
        for (int i = 0; i < 3; i++) begin
            tb_a = 6'(i*9 + 1);
            tick();
        end
        chk("R3 b_out held when idle", {90'd0, c1_b_out}, {90'd0, b_before});
        latch_now();
        chk("R3 image held when idle", c1_col, exp_fwd(0));
    endtask

    task automatic t_strobe_and_cascade();
        logic [95:0] kept = c1_col;
        for (int i = 16; i < 32; i++) push(6'((i*23 + 7) & 63), 6'h15);
        chk("R6 copy holds with strobe high", c1_col, kept);
        latch_now();
        chk("R6 copy loads on strobe", c1_col, exp_fwd(0));
        chk("R10 second block image", c2_col, exp_fwd(1));
        chk("R10 second block b_out", {90'd0, c2_b_out}, {90'd0, hist[0]});
    endtask

    task automatic t_reverse();
        dir_fwd = 1'b0;
        do_reset();
        tick();
        chk("R5 reverse enables", {94'd0, c2_a_oe, c2_b_oe}, 96'd2);
        for (int i = 0; i < 16; i++) begin
            push(6'((i*11 + 40) & 63), 6'((i*29 + 3) & 63));
            chk("R4 a_out word", {90'd0, c2_a_out}, {90'd0, word_at(nw - 16)});
        end
        latch_now();
        chk("R4 reverse column image", c2_col, exp_rev());
        chk("R11 a_in ignored reverse", c1_col, '0);
    endtask

    task automatic t_levels();
        blank_n = 1'b0; force_hi_n = 1'b1; #1;
        chk("R7 blank with data", c2_col, '0);
        blank_n = 1'b0; force_hi_n = 1'b0; #1;
        chk("R7 blank beats force", c2_col, '0);
        blank_n = 1'b1; force_hi_n = 1'b0; #1;
        chk("R8 force high", c2_col, '1);
        blank_n = 1'b1; force_hi_n = 1'b1; #1;
        chk("R9 data display", c2_col, exp_rev());
    endtask

    initial begin
        t_reset();
        t_forward();
        t_hold();
        t_strobe_and_cascade();
        t_reverse();
        t_levels();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule